// File: doc/BRIEF.md
# Single-Cell Battery Protection Supervisor

This block is the digital decision core of a protection circuit for one rechargeable lithium cell. Analog comparators outside the block report the conditions it acts on: whether the cell voltage is above the overvoltage level or below the charge-enable, undervoltage or depletion levels, whether the drop across the power switches exceeds the overcurrent level, whether the pack terminal has recovered, whether a charger is present and whether the die is too hot. From these the block sets the charge-switch and discharge-switch enables. It also drives a test-current enable, a recovery-path enable and a sleep request.

A fault is declared only after its condition has held for a programmable number of clock cycles. The only exception is over temperature, which cuts both switches at once. Each fault has its own release rule. The fault flags are sticky and can be read through a small register port. The host can turn either switch off through a control byte or through a dedicated power-off pin, and it clears the temperature flag by writing to that port.

Top module: `cell_guard`

## Requirements
- R1: After reset the flags read 0, both control bits read 1 (host_rdata = 8'h03), and with all condition inputs low both chg_en and dis_en are 1.
- R2: A delayed fault is declared only at the (D+1)-th consecutive rising edge with its condition high, where D is that fault's delay parameter. A shorter run sets no flag, and a run broken by even one low cycle restarts the count.
- R3: A qualified overvoltage sets host_rdata bit 7 and clears chg_en. dis_en stays 1.
- R4: The overvoltage flag is released at an edge where cell_lo_ce or drop_oc is high. chg_en then returns unless some other block is still active.
- R5: A qualified undervoltage sets host_rdata bit 6, clears both enables and raises sleep_req. It is released at an edge where cell_uv is low and chg_here is high.
- R6: A qualified depletion (cell_dep) sets the discharge-overcurrent flag, host_rdata bit 5, and clears both enables.
- R7: A qualified switch overdrop (drop_oc) sets host_rdata bit 5 and clears both enables.
- R8: The bit 5 flag is released only at an edge where pack_ok is high. While the flag is set, tst_en is 1, except during a depletion-caused fault while cell_dep is still high.
- R9: After a depletion-caused fault, once cell_dep is low, both tst_en and rcv_en are 1. rcv_en stays 0 for a fault caused only by overdrop.
- R10: hot clears chg_en and dis_en in the same cycle and sets host_rdata bit 4 at the next edge. That flag clears only on a host write with wdata bit 4 = 1 while hot is low. Until then both enables stay 0.
- R11: A host write loads wdata bit 0 as the charge permission and bit 1 as the discharge permission. Both read back at the same positions.
- R12: While pwr_off is high both enables are 0, and the flags are unaffected.
- R13: host_rdata bits 2 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_ov | input | 1 | Cell above overvoltage level |
| cell_lo_ce | input | 1 | Cell below charge-enable level |
| cell_uv | input | 1 | Cell below undervoltage level |
| cell_dep | input | 1 | Cell below depletion level |
| drop_oc | input | 1 | Switch drop above overcurrent level |
| pack_ok | input | 1 | Pack terminal recovered |
| chg_here | input | 1 | Charger present |
| hot | input | 1 | Over temperature |
| pwr_off | input | 1 | Dedicated power-off request |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Flags and control bits |
| chg_en | output | 1 | Charge switch enable |
| dis_en | output | 1 | Discharge switch enable |
| tst_en | output | 1 | Test-current enable |
| rcv_en | output | 1 | Recovery-path enable |
| sleep_req | output | 1 | Sleep request |

## Verification
Two pairs of events can meet in one cycle. The first pair is the overvoltage release and the overcurrent qualification, because both are driven by drop_oc. The bench sets the overvoltage flag, then holds drop_oc high. It checks that the flag is released at the first edge, that the charge switch is back on, and that the overcurrent fault appears at exactly edge D+1 with both switches off. The second pair is a host clear of the temperature flag written while hot is still high: the bench requires the flag to survive that write and to clear only on a later write made after cooling.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;
  // read-port bit positions (host-visible layout)
  localparam int unsigned RB_CHG = 0;
  localparam int unsigned RB_DIS = 1;
  localparam int unsigned RB_OT  = 4;
  localparam int unsigned RB_DOC = 5;
  localparam int unsigned RB_UV  = 6;
  localparam int unsigned RB_OV  = 7;

  typedef struct packed {
    logic ov;
    logic uv;
    logic doc;
    logic ot;
  } flags_t;
endpackage

// File: rtl/cg_rst_sync.sv
module cg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_s = sr_q[1];
endmodule

// File: rtl/cg_qual.sv
module cg_qual #(
  parameter int unsigned DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic fire
);
  localparam int unsigned W = (DLY < 1) ? 1 : $clog2(DLY + 1);
  localparam logic [W-1:0] LIM = W'(DLY);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    if (!cond)             cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fire = cond & (cnt_q == LIM);
endmodule

// File: rtl/cg_faults.sv
module cg_faults
  import cell_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ov_fire,
  input  logic   uv_fire,
  input  logic   sc_fire,
  input  logic   oc_fire,
  input  logic   cell_lo_ce,
  input  logic   drop_oc,
  input  logic   cell_uv,
  input  logic   chg_here,
  input  logic   pack_ok,
  input  logic   hot,
  input  logic   ot_clr,
  output flags_t flg,
  output logic   sc_cause
);
  flags_t flg_d;
  logic   sc_d;
  logic   flg_en;

  always_comb begin
    flg_d.ov  = ov_fire | (flg.ov & ~(cell_lo_ce | drop_oc));
    flg_d.uv  = uv_fire | (flg.uv & ~(~cell_uv & chg_here));
    flg_d.doc = sc_fire | oc_fire | (flg.doc & ~pack_ok);
    flg_d.ot  = hot | (flg.ot & ~ot_clr);
    sc_d      = sc_fire | (sc_cause & flg.doc & ~pack_ok);
    flg_en    = ({flg_d, sc_d} != {flg, sc_cause});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg      <= '0;
      sc_cause <= 1'b0;
    end else if (flg_en) begin
      flg      <= flg_d;
      sc_cause <= sc_d;
    end
  end
endmodule

// File: rtl/cg_host.sv
module cg_host
  import cell_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wperm,
  input  logic       wclr,
  output logic       ctl_chg,
  output logic       ctl_dis,
  output logic       ot_clr
);
  logic chg_d, dis_d;

  always_comb begin
    chg_d  = wr ? wperm[0] : ctl_chg;
    dis_d  = wr ? wperm[1] : ctl_dis;
    ot_clr = wr & wclr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_chg <= 1'b1;
      ctl_dis <= 1'b1;
    end else if (wr) begin
      ctl_chg <= chg_d;
      ctl_dis <= dis_d;
    end
  end
endmodule

// File: rtl/cell_guard.sv
module cell_guard
  import cell_guard_pkg::*;
#(
  parameter int unsigned OV_DLY = 1000,
  parameter int unsigned UV_DLY = 1000,
  parameter int unsigned SC_DLY = 20,
  parameter int unsigned OC_DLY = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_ov,
  input  logic       cell_lo_ce,
  input  logic       cell_uv,
  input  logic       cell_dep,
  input  logic       drop_oc,
  input  logic       pack_ok,
  input  logic       chg_here,
  input  logic       hot,
  input  logic       pwr_off,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       chg_en,
  output logic       dis_en,
  output logic       tst_en,
  output logic       rcv_en,
  output logic       sleep_req
);
  localparam int unsigned NQ = 4;
  localparam int unsigned QDLY [NQ] = '{OV_DLY, UV_DLY, SC_DLY, OC_DLY};

  logic          rst_n_s;
  logic [NQ-1:0] q_cond, q_fire;
  flags_t        flg;
  logic          sc_cause, ctl_chg, ctl_dis, ot_clr, blk_both;
  logic          unused_wbits;

  cg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign q_cond = {drop_oc, cell_dep, cell_uv, cell_ov};

  for (genvar i = 0; i < NQ; i++) begin : g_qual
    cg_qual #(.DLY(QDLY[i])) u_q (
      .clk(clk), .rst_n(rst_n_s), .cond(q_cond[i]), .fire(q_fire[i])
    );
  end

  cg_faults u_flt (
    .clk(clk), .rst_n(rst_n_s),
    .ov_fire(q_fire[0]), .uv_fire(q_fire[1]), .sc_fire(q_fire[2]), .oc_fire(q_fire[3]),
    .cell_lo_ce(cell_lo_ce), .drop_oc(drop_oc), .cell_uv(cell_uv), .chg_here(chg_here),
    .pack_ok(pack_ok), .hot(hot), .ot_clr(ot_clr), .flg(flg), .sc_cause(sc_cause)
  );

  cg_host u_host (
    .clk(clk), .rst_n(rst_n_s), .wr(host_wr),
    .wperm(host_wdata[RB_DIS:RB_CHG]), .wclr(host_wdata[RB_OT]),
    .ctl_chg(ctl_chg), .ctl_dis(ctl_dis), .ot_clr(ot_clr)
  );

  assign unused_wbits = ^{host_wdata[7:5], host_wdata[3:2]};

  always_comb begin
    blk_both  = flg.uv | flg.doc | flg.ot | hot | pwr_off;
    chg_en    = ~blk_both & ~flg.ov & ctl_chg;
    dis_en    = ~blk_both & ctl_dis;
    tst_en    = flg.doc & ~(sc_cause & cell_dep);
    rcv_en    = flg.doc & sc_cause & ~cell_dep;
    sleep_req = flg.uv;
    host_rdata         = '0;
    host_rdata[RB_CHG] = ctl_chg;
    host_rdata[RB_DIS] = ctl_dis;
    host_rdata[RB_OT]  = flg.ot;
    host_rdata[RB_DOC] = flg.doc;
    host_rdata[RB_UV]  = flg.uv;
    host_rdata[RB_OV]  = flg.ov;
  end
endmodule

// File: rtl/cg_chk.sv
module cg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cell_uv,
  input logic       cell_dep,
  input logic       pack_ok,
  input logic       hot,
  input logic       pwr_off,
  input logic       host_wr,
  input logic       wr_clr,
  input logic [3:0] rd_flags,
  input logic       rd_dis,
  input logic       chg_en,
  input logic       dis_en,
  input logic       tst_en,
  input logic       rcv_en
);
  // rd_flags = {ov, uv, doc, ot}

  // R10
  hot_cuts_fets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> (!chg_en && !dis_en));

  // R12
  pwr_off_cuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (!chg_en && !dis_en));

  // R3
  ov_keeps_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags == 4'b1000 && rd_dis && !hot && !pwr_off) |-> (dis_en && !chg_en));

  // R5
  uv_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_flags[2]) |-> $past(cell_uv));

  // R8
  doc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_flags[1]) |-> $past(pack_ok));

  // R10
  ot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_flags[0]) |-> $past(host_wr && wr_clr && !hot));

  // R9
  rcv_with_tst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_en |-> (tst_en && !cell_dep));
endmodule

bind cell_guard cg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cell_uv(cell_uv), .cell_dep(cell_dep),
  .pack_ok(pack_ok), .hot(hot), .pwr_off(pwr_off), .host_wr(host_wr),
  .wr_clr(host_wdata[4]), .rd_flags(host_rdata[7:4]), .rd_dis(host_rdata[1]),
  .chg_en(chg_en), .dis_en(dis_en), .tst_en(tst_en), .rcv_en(rcv_en)
);

// File: tb/cell_guard_tb.sv
module cell_guard_tb;
  localparam int OVD = 4, UVD = 3, SCD = 2, OCD = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic cell_ov, cell_lo_ce, cell_uv, cell_dep, drop_oc, pack_ok, chg_here, hot, pwr_off;
  logic host_wr;
  logic [7:0] host_wdata, host_rdata;
  logic chg_en, dis_en, tst_en, rcv_en, sleep_req;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  cell_guard #(.OV_DLY(OVD), .UV_DLY(UVD), .SC_DLY(SCD), .OC_DLY(OCD)) u_dut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] v);
    host_wr = 1'b1; host_wdata = v;
    tick(1);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic set_cond(input int w, input logic v);
    case (w)
      0: cell_ov = v;
      1: cell_uv = v;
      2: cell_dep = v;
      default: drop_oc = v;
    endcase
  endtask

  function automatic int flag_bit(input int w);
    case (w)
      0: return 7;
      1: return 6;
      default: return 5;
    endcase
  endfunction

  // R2 sweep of hold lengths plus R3..R9 outcomes per fault
  task automatic sweep(input int w, input int d);
    int b;
    b = flag_bit(w);
    for (int len = 1; len <= d + 2; len++) begin
      set_cond(w, 1'b1);
      tick(len);
      chk("R2 qual", 8'(host_rdata[b]), 8'(len > d));
      if (len > d) begin
        case (w)
          0: begin chk("R3 chg", 8'(chg_en), 8'd0); chk("R3 dis", 8'(dis_en), 8'd1); end
          1: begin chk("R5 en", {chg_en, dis_en}, 8'd0); chk("R5 sleep", 8'(sleep_req), 8'd1); end
          2: begin chk("R6 en", {chg_en, dis_en}, 8'd0); chk("R8 tst held", {tst_en, rcv_en}, 8'd0); end
          default: begin chk("R7 en", {chg_en, dis_en}, 8'd0); chk("R9 oc tst/rcv", {tst_en, rcv_en}, 8'h2); end
        endcase
      end
      set_cond(w, 1'b0);
      tick(1);
      chk("R2 sticky", 8'(host_rdata[b]), 8'(len > d));
      if (len > d && w == 2) chk("R9 sc tst/rcv", {tst_en, rcv_en}, 8'h3);
      case (w)
        0: cell_lo_ce = 1'b1;
        1: chg_here = 1'b1;
        default: pack_ok = 1'b1;
      endcase
      tick(1);
      cell_lo_ce = 1'b0; chg_here = 1'b0; pack_ok = 1'b0;
      chk("R4/R5/R8 release", host_rdata, 8'h03);
      chk("R4/R5/R8 enables", {chg_en, dis_en, tst_en, rcv_en, sleep_req}, 8'h18);
    end
    // broken run restarts count
    set_cond(w, 1'b1); tick(d);
    set_cond(w, 1'b0); tick(1);
    set_cond(w, 1'b1); tick(d);
    chk("R2 restart", 8'(host_rdata[b]), 8'd0);
    set_cond(w, 1'b0); tick(1);
  endtask

  initial begin
    rst_n = 1'b0;
    {cell_ov, cell_lo_ce, cell_uv, cell_dep, drop_oc, pack_ok, chg_here, hot, pwr_off} = '0;
    host_wr = 1'b0; host_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R1 rdata", host_rdata, 8'h03);
    chk("R1 outs", {chg_en, dis_en, tst_en, rcv_en, sleep_req}, 8'h18);

    sweep(0, OVD);
    sweep(1, UVD);
    sweep(2, SCD);
    sweep(3, OCD);

    // R4 with R7: overvoltage released by drop_oc while overdrop qualifies
    cell_ov = 1'b1; tick(OVD + 1); cell_ov = 1'b0;
    chk("R3 set", host_rdata, 8'h83);
    drop_oc = 1'b1; tick(1);
    chk("R4 drop release", host_rdata, 8'h03);
    chk("R4 chg back", 8'(chg_en), 8'd1);
    tick(OCD - 1);
    chk("R7 not yet", 8'(host_rdata[5]), 8'd0);
    tick(1);
    chk("R7 doc", host_rdata, 8'h23);
    chk("R7 fets", {chg_en, dis_en, rcv_en}, 8'd0);
    drop_oc = 1'b0; tick(2);
    chk("R8 held", 8'(host_rdata[5]), 8'd1);
    pack_ok = 1'b1; tick(1); pack_ok = 1'b0;
    chk("R8 release", host_rdata, 8'h03);

    // R10 over temperature
    hot = 1'b1; #1;
    chk("R10 immediate", {chg_en, dis_en}, 8'd0);
    tick(1);
    chk("R10 flag", host_rdata, 8'h13);
    host_write(8'h13);
    chk("R10 clear while hot", host_rdata, 8'h13);
    hot = 1'b0; tick(2);
    chk("R10 cool no ack", host_rdata, 8'h13);
    chk("R10 fets off", {chg_en, dis_en}, 8'd0);
    host_write(8'h13);
    chk("R10 acked", host_rdata, 8'h03);
    chk("R10 fets on", {chg_en, dis_en}, 8'h3);

    // R11 host permissions, R13 reserved bits
    for (int v = 0; v < 4; v++) begin
      host_write(8'(v));
      chk("R11 readback", host_rdata, 8'(v));
      chk("R11 fets", {chg_en, dis_en}, 8'({v[0], v[1]}));
    end
    host_write(8'hEC);
    chk("R13 reserved", host_rdata, 8'h00);
    host_write(8'h03);

    // R12 power-off pin, flags kept
    cell_ov = 1'b1; tick(OVD + 1); cell_ov = 1'b0;
    pwr_off = 1'b1; tick(1);
    chk("R12 fets", {chg_en, dis_en}, 8'd0);
    chk("R12 flags", host_rdata, 8'h83);
    pwr_off = 1'b0; tick(1);
    chk("R12 dis back", {chg_en, dis_en}, 8'h1);
    cell_lo_ce = 1'b1; tick(1); cell_lo_ce = 1'b0;
    chk("R4 lo_ce release", {host_rdata[7], chg_en}, 8'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule